// File: doc/BRIEF.md
# Half-Step Clock Pre-Divider

This block divides a clock by a ratio that moves in steps of one half. It runs on a reference tick at twice the rate of the clock being divided, so one tick is one half-period of that clock. It produces its result as a one-tick clock-enable pulse train rather than as a new clock, which keeps every downstream register on the same tick domain and leaves the block fully synchronous.

The ratio comes from an encoded divider field. A value of 0 means bypass: one pulse per period of the divided clock, which is every 2 ticks. A nonzero value h gives an output rate of input × 2 / (h + 1), which is one pulse every h + 1 ticks. Odd values of h give whole-number ratios and even values give ratios ending in one half. The caller presents a new value together with a load strobe. The value is held as pending and is adopted only at the next output pulse, so a period that is under way always runs to its full length.

Top module: `halfstep_prediv`

## Requirements
- R1: While reset is high the output is low. After reset is released, with the reset divider value 0, the first pulse is registered on the 2nd rising edge, and the edge right after release never produces a pulse.
- R2: A divider value of 0 (bypass) gives one pulse every 2 ticks.
- R3: A nonzero divider value h gives one pulse every h + 1 ticks. For example, 1→2, 2→3, 3→4 and 4→5 ticks.
- R4: Every output pulse is exactly one tick wide, and two pulses are never adjacent.
- R5: A value loaded part way through a period does not change that period. It applies from the period that starts at the next pulse.
- R6: If several loads arrive before one boundary, only the last of them takes effect.
- R7: A load sampled on the same edge as a pulse applies to the period that starts with that pulse.
- R8: Changes on the divider field while the load strobe is low have no effect on the pulse spacing.
- R9: The largest field value, 2^W − 1, gives a spacing of 2^W ticks, and no gap between pulses ever exceeds 2^W ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate reference tick. |
| rst | input | 1 | Synchronous active-high reset. |
| div_field | input | W | Encoded divider value: 0 is bypass, h gives a ratio of (h+1)/2. |
| div_load | input | 1 | Strobe that captures div_field as the pending value. |
| tick_en | output | 1 | One-tick clock-enable pulse at the divided rate. |

## Verification
The bench builds the block with W = 4. With that width the whole range of divider values can be reached, from bypass up to a 16-tick spacing at field value 15, together with both odd and even values around the half-step boundary. The short periods also make it practical to time a load onto the exact edge of a pulse, so the R7 case is exercised deliberately. A behavioural model tracks ticks since the last pulse, the pending value and the active value, and it predicts the output on every cycle. Targeted gap measurements separately confirm each spacing.

// File: rtl/hdiv_pkg.sv
package hdiv_pkg;

    localparam int DEFAULT_W = 4;

    // Where the next active divider value comes from at a boundary.
    typedef enum logic [1:0] {
        UPD_NONE = 2'd0,
        UPD_PEND = 2'd1,
        UPD_LOAD = 2'd2
    } upd_e;

    // Index of the last tick in a period: period is h+1, bypass is 2.
    function automatic int unsigned last_tick(input int unsigned h);
        return (h == 0) ? 1 : h;
    endfunction

endpackage

// File: rtl/hdiv_cfg.sv
module hdiv_cfg #(
    parameter int W           = hdiv_pkg::DEFAULT_W,
    parameter int RESET_FIELD = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] field,
    input  logic         boundary,
    output logic [W-1:0] act,
    output logic [W-1:0] pend
);
    import hdiv_pkg::*;

    localparam logic [W-1:0] RST_VAL = W'(RESET_FIELD);

    upd_e upd_sel;

    always_comb begin
        if (!boundary)  upd_sel = UPD_NONE;
        else if (load)  upd_sel = UPD_LOAD;
        else            upd_sel = UPD_PEND;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= RST_VAL;
            act  <= RST_VAL;
        end else begin
            if (load) pend <= field;
            case (upd_sel)
                UPD_LOAD: act <= field;
                UPD_PEND: act <= pend;
                default:  act <= act;
            endcase
        end
    end
endmodule

// File: rtl/hdiv_count.sv
module hdiv_count #(
    parameter int W = hdiv_pkg::DEFAULT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] act,
    output logic         wrap,
    output logic         en_q
);
    logic [W-1:0] cnt;
    logic [W-1:0] last;

    assign last = W'(hdiv_pkg::last_tick(int'(act)));
    assign wrap = (cnt == last);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            en_q <= 1'b0;
        end else begin
            cnt  <= wrap ? '0 : cnt + 1'b1;
            en_q <= wrap;
        end
    end
endmodule

// File: rtl/halfstep_prediv.sv
module halfstep_prediv #(
    parameter int W           = hdiv_pkg::DEFAULT_W,
    parameter int RESET_FIELD = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] div_field,
    input  logic         div_load,
    output logic         tick_en
);
    logic [W-1:0] act_w;
    logic [W-1:0] pend_w;
    logic         wrap_w;

    hdiv_cfg #(.W(W), .RESET_FIELD(RESET_FIELD)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .load     (div_load),
        .field    (div_field),
        .boundary (wrap_w),
        .act      (act_w),
        .pend     (pend_w)
    );

    hdiv_count #(.W(W)) u_count (
        .clk  (clk),
        .rst  (rst),
        .act  (act_w),
        .wrap (wrap_w),
        .en_q (tick_en)
    );
endmodule

// File: rtl/halfstep_prediv_chk.sv
module halfstep_prediv_chk #(
    parameter int W = hdiv_pkg::DEFAULT_W
) (
    input logic         clk,
    input logic         rst,
    input logic         load,
    input logic         en_out,
    input logic         wrap,
    input logic [W-1:0] act,
    input logic [W-1:0] pend
);
    logic [W:0] gap;

    always_ff @(posedge clk) begin
        if (rst)          gap <= '0;
        else if (en_out)  gap <= '0;
        else if (!gap[W]) gap <= gap + 1'b1;
    end

    p_quiet_in_reset_r1: assert property (@(posedge clk) rst |=> !en_out);

    p_no_pulse_on_release_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !en_out);

    p_single_tick_r4: assert property (@(posedge clk) disable iff (rst)
        en_out |=> !en_out);

    p_wrap_gives_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        wrap |=> en_out);

    p_act_held_mid_period_r5: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(act));

    p_pend_ignores_field_r8: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(pend));

    p_gap_bound_r9: assert property (@(posedge clk) disable iff (rst)
        !gap[W]);
endmodule

bind halfstep_prediv halfstep_prediv_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .load   (div_load),
    .en_out (tick_en),
    .wrap   (wrap_w),
    .act    (act_w),
    .pend   (pend_w)
);

// File: tb/halfstep_prediv_bench.sv
module halfstep_prediv_bench;
    localparam int W          = 4;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] div_field = '0;
    logic         div_load = 1'b0;
    logic         tick_en;

    int    total = 0;
    int    bad   = 0;
    string cur_req = "R1";
    bit    finished = 1'b0;

    // behavioural model state
    int m_since = 0;
    int m_per   = 2;
    int m_pend  = 0;
    bit m_exp   = 1'b0;

    halfstep_prediv #(.W(W)) u_halfstep_prediv (
        .clk       (clk),
        .rst       (rst),
        .div_field (div_field),
        .div_load  (div_load),
        .tick_en   (tick_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int spacing(input int h);
        return (h == 0) ? 2 : h + 1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_since = 0; m_per = 2; m_pend = 0; m_exp = 1'b0;
        end else begin
            m_since++;
            if (m_since == m_per) begin
                m_exp   = 1'b1;
                m_since = 0;
                m_per   = spacing(div_load ? int'(div_field) : m_pend);
            end else begin
                m_exp = 1'b0;
            end
            if (div_load) m_pend = int'(div_field);
        end
    end

    always @(negedge clk) begin
        if (!finished) chk(tick_en == m_exp, {cur_req, " model"}, int'(tick_en), int'(m_exp));
    end

    task automatic do_load(input int v);
        div_field = W'(v);
        div_load  = 1'b1;
        @(negedge clk);
        div_load  = 1'b0;
    endtask

    task automatic wait_pulse();
        do @(negedge clk); while (!tick_en);
    endtask

    task automatic measure(input int exp_gap, input string req);
        int g;
        wait_pulse();
        g = 0;
        do begin @(negedge clk); g++; end while (!tick_en);
        chk(g == exp_gap, {req, " gap"}, g, exp_gap);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > WATCHDOG) begin
                chk(1'b0, "watchdog", cyc, WATCHDOG);
                finish_run();
            end
        end
    end

    initial begin
        int g;
        repeat (3) @(negedge clk);
        // R1: output low in reset
        chk(tick_en == 1'b0, "R1 reset", int'(tick_en), 0);
        rst = 1'b0;
        g = 0;
        do begin @(negedge clk); g++; end while (!tick_en);
        chk(g == 2, "R1 first pulse", g, 2);

        cur_req = "R2";
        measure(2, "R2");
        measure(2, "R2");

        cur_req = "R3";
        do_load(3); measure(4, "R3 h=3"); measure(4, "R3 h=3");
        do_load(4); measure(5, "R3 h=4");
        do_load(2); measure(3, "R3 h=2");
        do_load(1); measure(2, "R3 h=1");
        do_load(0); measure(2, "R3 back to bypass");

        cur_req = "R9";
        do_load(15); measure(16, "R9 max"); measure(16, "R9 max");

        // R5: load mid-period leaves current period intact
        cur_req = "R5";
        wait_pulse();
        repeat (5) @(negedge clk);
        do_load(2);
        g = 6;
        while (!tick_en) begin @(negedge clk); g++; end
        chk(g == 16, "R5 old period kept", g, 16);
        measure(3, "R5 new period");

        // R6: last of several loads wins
        cur_req = "R6";
        wait_pulse();
        do_load(6);
        do_load(8);
        measure(9, "R6 last load");

        // R7: load on the pulse edge
        cur_req = "R7";
        do_load(2);
        measure(3, "R7 setup");
        repeat (2) @(negedge clk);
        div_field = W'(5);
        div_load  = 1'b1;
        @(negedge clk);
        div_load  = 1'b0;
        chk(tick_en == 1'b1, "R7 pulse on load edge", int'(tick_en), 1);
        g = 0;
        do begin @(negedge clk); g++; end while (!tick_en);
        chk(g == 6, "R7 load applied at once", g, 6);

        // R8: field change without load ignored
        cur_req = "R8";
        div_field = W'(9);
        measure(6, "R8 no load");
        div_field = W'(0);
        measure(6, "R8 no load");

        cur_req = "R4";
        do_load(0);
        repeat (20) @(negedge clk);

        finish_run();
    end
endmodule